// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error and Break Detection

This block turns an asynchronous serial line into characters. It is clocked by a receive clock that runs at 1, 16 or 64 times the bit rate. While enabled, it hunts for a falling edge on the line. At the 16X and 64X rates it checks the start bit again at its middle and drops it if the line has gone high. It then samples 5 to 8 data bits, least significant first, plus an optional parity bit and one stop bit, each at the middle of the bit. A finished character moves from the shift register into a holding register and raises a ready flag. The host clears that flag with a read strobe.

The block keeps four sticky status flags: parity error, overrun, framing error and line break. They stay set until the host pulses an error-clear input or reset is asserted. A frame whose data bits, parity bit and stop bit are all zero counts as a break. It sets the break flag and no character is delivered. The receiver then waits for the line to return high before it hunts for a new start bit.

The controller has six states. HUNT waits for a low line. START confirms the start bit at mid-bit, and goes back to HUNT on a false start or on to DATA. DATA samples the data bits and goes to PARITY or STOP after the last one. PARITY samples one bit and goes to STOP. STOP samples the stop bit and goes to HUNT, or to BRKWAIT when the frame is a break. BRKWAIT goes back to HUNT once the line is high. At 1X, HUNT goes straight to DATA. A low enable forces the controller into HUNT from any state.

Top module: `async_rx_core`

## Requirements
- R1: After reset, `rx_ready` is 0, `hold_data` is 0 and all four status flags are 0.
- R2: `cfg_len` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first. Unused upper bits of `hold_data` read 0. `hold_data` changes only when a character is delivered.
- R3: `cfg_mult` selects the rate: 00 is 1X, 01 is 16X, 10 or 11 is 64X. At 16X and 64X the line is sampled again half a bit time after the falling edge. If it is high there, the start is treated as false: no character, no flag, and hunting resumes.
- R4: `cfg_par_en`=1 adds a parity bit after the data bits. It is even parity when `cfg_par_odd`=0 and odd parity when it is 1. A mismatch sets `err_parity`, and the character is still delivered.
- R5: A stop-bit sample of 0 in a frame that is not a break sets `err_framing`, and the character is still delivered.
- R6: If every data, parity and stop sample is 0, `brk_det` is set, `err_framing` stays clear, and `rx_ready` and `hold_data` are left unchanged. No new start is accepted until the line has been high.
- R7: `rx_ready` rises one clock after the stop-bit sample and falls after a clock with `rd_strobe`=1. A delivery in the same clock as a read wins.
- R8: If a character is delivered while `rx_ready` is 1 and no read happens in that clock, `err_overrun` is set and the new character replaces `hold_data`.
- R9: The four status flags are sticky. Only `err_clear` or reset clears them, and a new set in the same clock as a clear wins.
- R10: While `rx_enable` is 0, the line is ignored and no character or flag is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock at the selected multiple of the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_serial | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Receiver enable |
| cfg_mult | input | 2 | Clock multiplier select |
| cfg_len | input | 2 | Character length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| rd_strobe | input | 1 | Holding register read, clears ready |
| err_clear | input | 1 | Clears the four status flags |
| hold_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | A character is waiting in the holding register |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_framing | output | 1 | Sticky framing error |
| brk_det | output | 1 | Sticky line break |

## Verification
A wrong bit counter or a wrong state transition moves every later sample by whole bit times. The fault shows up as a shifted or truncated value in `hold_data` when the next character is delivered, which is one frame time after the fault. A bad mid-bit sample count shows only on frames with a false start: a stray character or a flag appears within about one frame. Faults in the holding or flag logic show at the first delivery, read or clear that touches them, within two clocks. The tests therefore mix rates, lengths and parity settings, and they provoke each error and the break on purpose.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int unsigned CHAR_W = 8;
    localparam int unsigned FLAG_N = 4;

    localparam int unsigned FLG_PAR = 0;
    localparam int unsigned FLG_OVR = 1;
    localparam int unsigned FLG_FRM = 2;
    localparam int unsigned FLG_BRK = 3;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
        logic              brk;
    } rx_char_t;

endpackage

// File: rtl/async_rx_timer.sv
module async_rx_timer #(
    parameter  int unsigned MID_DIV = 16,
    parameter  int unsigned MAX_DIV = 64,
    localparam int unsigned CNT_W   = $clog2(MAX_DIV)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] cfg_mult,
    output logic       half_hit,
    output logic       full_hit
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] full_m1;
    logic [CNT_W-1:0] half_m1;

    // terminal counts for the selected multiplier
    always_comb begin
        unique case (cfg_mult)
            2'b00: begin
                full_m1 = '0;
                half_m1 = '0;
            end
            2'b01: begin
                full_m1 = CNT_W'(MID_DIV - 1);
                half_m1 = CNT_W'(MID_DIV / 2 - 1);
            end
            default: begin
                full_m1 = CNT_W'(MAX_DIV - 1);
                half_m1 = CNT_W'(MAX_DIV / 2 - 1);
            end
        endcase
    end

    assign full_hit = (cnt_q == full_m1);
    assign half_hit = (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || full_hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/async_rx_fsm.sv
module async_rx_fsm
    import async_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_serial,
    input  logic       rx_enable,
    input  logic [1:0] cfg_mult,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       half_hit,
    input  logic       full_hit,
    output logic       timer_restart,
    output logic       chr_valid,
    output rx_char_t   chr
);

    localparam int unsigned IDX_W = $clog2(CHAR_W);

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic [CHAR_W-1:0] shift_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic              all_zero_q;
    logic              par_bit_q;
    logic              last_bit;
    logic              brk_cond;
    logic              par_expect;
    logic              one_x;

    assign one_x      = (cfg_mult == 2'b00);
    // final data index is 4 + cfg_len (lengths 5..8)
    assign last_bit   = (bit_idx_q == {1'b1, cfg_len});
    assign brk_cond   = all_zero_q && !rx_serial;
    assign par_expect = (^shift_q) ^ cfg_par_odd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT: begin
                if (!rx_serial) begin
                    state_d = one_x ? RX_DATA : RX_START;
                end
            end
            RX_START: begin
                if (half_hit) begin
                    state_d = rx_serial ? RX_HUNT : RX_DATA;
                end
            end
            RX_DATA: begin
                if (full_hit && last_bit) begin
                    state_d = cfg_par_en ? RX_PAR : RX_STOP;
                end
            end
            RX_PAR: begin
                if (full_hit) begin
                    state_d = RX_STOP;
                end
            end
            RX_STOP: begin
                if (full_hit) begin
                    state_d = brk_cond ? RX_BRKWAIT : RX_HUNT;
                end
            end
            RX_BRKWAIT: begin
                if (rx_serial) begin
                    state_d = RX_HUNT;
                end
            end
            default: state_d = RX_HUNT;
        endcase
        if (!rx_enable) begin
            state_d = RX_HUNT;
        end
    end

    assign timer_restart = (state_q == RX_HUNT) || (state_d != state_q);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            bit_idx_q  <= '0;
            all_zero_q <= 1'b1;
            par_bit_q  <= 1'b0;
            chr_valid  <= 1'b0;
            chr        <= '0;
        end else begin
            chr_valid <= 1'b0;
            unique case (state_q)
                RX_HUNT: begin
                    shift_q    <= '0;
                    bit_idx_q  <= '0;
                    all_zero_q <= 1'b1;
                    par_bit_q  <= 1'b0;
                end
                RX_DATA: begin
                    if (full_hit) begin
                        shift_q[bit_idx_q] <= rx_serial;
                        all_zero_q         <= all_zero_q && !rx_serial;
                        bit_idx_q          <= bit_idx_q + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (full_hit) begin
                        par_bit_q  <= rx_serial;
                        all_zero_q <= all_zero_q && !rx_serial;
                    end
                end
                RX_STOP: begin
                    if (full_hit && rx_enable) begin
                        chr_valid   <= 1'b1;
                        chr.data    <= shift_q;
                        chr.par_err <= cfg_par_en && (par_bit_q != par_expect);
                        chr.frm_err <= !rx_serial && !brk_cond;
                        chr.brk     <= brk_cond;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  rx_char_t          chr,
    input  logic              rd_strobe,
    input  logic              err_clear,
    output logic [CHAR_W-1:0] hold_data,
    output logic              rx_ready,
    output logic [FLAG_N-1:0] flags
);

    logic              deliver;
    logic [FLAG_N-1:0] flag_set;

    assign deliver = chr_valid && !chr.brk;

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_PAR] = deliver && chr.par_err;
        flag_set[FLG_OVR] = deliver && rx_ready && !rd_strobe;
        flag_set[FLG_FRM] = deliver && chr.frm_err;
        flag_set[FLG_BRK] = chr_valid && chr.brk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            rx_ready  <= 1'b0;
        end else begin
            if (deliver) begin
                hold_data <= chr.data;
                rx_ready  <= 1'b1;
            end else if (rd_strobe) begin
                rx_ready  <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (flag_set[g]) begin
                flags[g] <= 1'b1;
            end else if (err_clear) begin
                flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int unsigned MID_DIV = 16,
    parameter int unsigned MAX_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_serial,
    input  logic       rx_enable,
    input  logic [1:0] cfg_mult,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_strobe,
    input  logic       err_clear,
    output logic [7:0] hold_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       err_framing,
    output logic       brk_det
);

    logic              half_hit;
    logic              full_hit;
    logic              timer_restart;
    logic              chr_valid;
    rx_char_t          chr;
    logic [FLAG_N-1:0] flags;

    async_rx_timer #(
        .MID_DIV (MID_DIV),
        .MAX_DIV (MAX_DIV)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (timer_restart),
        .cfg_mult (cfg_mult),
        .half_hit (half_hit),
        .full_hit (full_hit)
    );

    async_rx_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_serial     (rx_serial),
        .rx_enable     (rx_enable),
        .cfg_mult      (cfg_mult),
        .cfg_len       (cfg_len),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_odd   (cfg_par_odd),
        .half_hit      (half_hit),
        .full_hit      (full_hit),
        .timer_restart (timer_restart),
        .chr_valid     (chr_valid),
        .chr           (chr)
    );

    async_rx_hold hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr_valid (chr_valid),
        .chr       (chr),
        .rd_strobe (rd_strobe),
        .err_clear (err_clear),
        .hold_data (hold_data),
        .rx_ready  (rx_ready),
        .flags     (flags)
    );

    assign err_parity  = flags[FLG_PAR];
    assign err_overrun = flags[FLG_OVR];
    assign err_framing = flags[FLG_FRM];
    assign brk_det     = flags[FLG_BRK];

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk
    import async_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_enable,
    input logic       rd_strobe,
    input logic       err_clear,
    input logic       chr_valid,
    input rx_char_t   chr,
    input logic [7:0] hold_data,
    input logic       rx_ready,
    input logic       err_parity,
    input logic       err_overrun,
    input logic       brk_det
);

    AST_READY_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && !chr.brk |=> rx_ready); // R7

    AST_READY_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && rd_strobe && !chr_valid |=> !rx_ready); // R7

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && !chr.brk && rx_ready && !rd_strobe |=> err_overrun); // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun && !err_clear |=> err_overrun); // R9

    AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity && !err_clear |=> err_parity); // R9

    AST_BREAK_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && chr.brk && !rx_ready |=> !rx_ready && brk_det); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(chr_valid && !chr.brk) |=> $stable(hold_data)); // R2

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !chr_valid); // R10

endmodule

bind async_rx_core async_rx_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .rd_strobe   (rd_strobe),
    .err_clear   (err_clear),
    .chr_valid   (chr_valid),
    .chr         (chr),
    .hold_data   (hold_data),
    .rx_ready    (rx_ready),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .brk_det     (brk_det)
);

// File: tb/async_rx_core_tb_top.sv
module async_rx_core_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b1;
    logic [1:0] cfg_mult = 2'b01;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       mon_rd = 1'b0;
    logic       man_rd = 1'b0;
    logic       rd_strobe;
    logic       err_clear = 1'b0;
    logic [7:0] hold_data;
    logic       rx_ready, err_parity, err_overrun, err_framing, brk_det;

    int checks = 0;
    int errors = 0;
    bit auto_rd = 1'b1;
    logic [7:0] exp_q[$];

    assign rd_strobe = mon_rd | man_rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    async_rx_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_serial   (rx_line),
        .rx_enable   (rx_enable),
        .cfg_mult    (cfg_mult),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .rd_strobe   (rd_strobe),
        .err_clear   (err_clear),
        .hold_data   (hold_data),
        .rx_ready    (rx_ready),
        .err_parity  (err_parity),
        .err_overrun (err_overrun),
        .err_framing (err_framing),
        .brk_det     (brk_det)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a character is waiting
    always @(negedge clk) begin
        if (auto_rd && rx_ready && !mon_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected character: actual %0h expected none", hold_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (hold_data !== e) begin
                    errors++;
                    $display("FAIL R2 data: actual %0h expected %0h", hold_data, e);
                end
            end
            mon_rd = 1'b1;
        end else begin
            mon_rd = 1'b0;
        end
    end

    function automatic int div_of(input logic [1:0] m);
        return (m == 2'b00) ? 1 : (m == 2'b01) ? 16 : 64;
    endfunction

    task automatic idle_bits(input int n);
        repeat (n * div_of(cfg_mult)) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_v);
        int nb, dv;
        logic p;
        nb = 5 + int'(cfg_len);
        dv = div_of(cfg_mult);
        p = cfg_par_odd ^ bad_par;
        for (int i = 0; i < nb; i++) p ^= d[i];
        rx_line = 1'b0;
        repeat (dv) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_line = d[i];
            repeat (dv) @(negedge clk);
        end
        if (cfg_par_en) begin
            rx_line = p;
            repeat (dv) @(negedge clk);
        end
        rx_line = stop_v;
        repeat (dv) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * dv) @(negedge clk);
    endtask

    // driver: expected value pushed, then the frame is sent
    task automatic send_ok(input logic [7:0] d, input bit bad_par, input bit stop_v);
        exp_q.push_back(d & 8'((1 << (5 + int'(cfg_len))) - 1));
        send_frame(d, bad_par, stop_v);
    endtask

    task automatic set_cfg(input logic [1:0] m, input int nb, input bit pen, input bit podd);
        cfg_mult = m;
        cfg_len = 2'(nb - 5);
        cfg_par_en = pen;
        cfg_par_odd = podd;
        @(negedge clk);
    endtask

    task automatic clear_errs();
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_flags(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {brk_det, err_framing, err_overrun, err_parity};
        check(act === exp, req, act, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rx_ready === 1'b0, "R1 ready", rx_ready, 0);
        check(hold_data === 8'h00, "R1 hold", hold_data, 0);
        check_flags("R1 flags", 4'b0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3 16X, 8 bits
        set_cfg(2'b01, 8, 1'b0, 1'b0);
        send_ok(8'hA5, 1'b0, 1'b1);
        send_ok(8'h3C, 1'b0, 1'b1);
        // R3 R4 1X, 7 bits even parity
        set_cfg(2'b00, 7, 1'b1, 1'b0);
        send_ok(8'h55, 1'b0, 1'b1);
        send_ok(8'h2A, 1'b0, 1'b1);
        // R2 R4 64X, 5 bits odd parity, upper bits masked
        set_cfg(2'b10, 5, 1'b1, 1'b1);
        send_ok(8'h13, 1'b0, 1'b1);
        send_ok(8'hFF, 1'b0, 1'b1);
        idle_bits(2);
        check_flags("R4 good parity no flags", 4'b0000);
        check(exp_q.size() == 0, "R2 all delivered", exp_q.size(), 0);

        // R4 parity error, character still delivered
        set_cfg(2'b01, 8, 1'b1, 1'b0);
        send_ok(8'h6E, 1'b1, 1'b1);
        idle_bits(2);
        check_flags("R4 parity flag", 4'b0001);
        idle_bits(3);
        check_flags("R9 parity sticky", 4'b0001);
        clear_errs();
        check_flags("R9 cleared", 4'b0000);

        // R5 framing error, delivered; later character fine
        set_cfg(2'b01, 8, 1'b0, 1'b0);
        send_ok(8'h81, 1'b0, 1'b0);
        idle_bits(2);
        check_flags("R5 framing flag", 4'b0100);
        send_ok(8'h42, 1'b0, 1'b1);
        clear_errs();

        // R3 false start at 16X
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        idle_bits(15);
        check(rx_ready === 1'b0, "R3 false start no char", rx_ready, 0);
        check_flags("R3 false start no flags", 4'b0000);
        check(exp_q.size() == 0, "R3 nothing queued", exp_q.size(), 0);
        send_ok(8'hC3, 1'b0, 1'b1);

        // R3 false start at 64X
        set_cfg(2'b10, 8, 1'b0, 1'b0);
        rx_line = 1'b0;
        repeat (20) @(negedge clk);
        rx_line = 1'b1;
        idle_bits(12);
        check_flags("R3 64X false start no flags", 4'b0000);
        send_ok(8'h5A, 1'b0, 1'b1);

        // R6 break
        set_cfg(2'b01, 8, 1'b1, 1'b1);
        rx_line = 1'b0;
        idle_bits(16);
        check(brk_det === 1'b1, "R6 break flagged", brk_det, 1);
        check(err_framing === 1'b0, "R6 no framing on break", err_framing, 0);
        check(rx_ready === 1'b0, "R6 no char on break", rx_ready, 0);
        rx_line = 1'b1;
        idle_bits(2);
        send_ok(8'h99, 1'b0, 1'b1);
        idle_bits(1);
        check(exp_q.size() == 0, "R6 resumes after break", exp_q.size(), 0);
        clear_errs();
        check_flags("R9 break cleared", 4'b0000);

        // R8 overrun
        set_cfg(2'b01, 8, 1'b0, 1'b0);
        auto_rd = 1'b0;
        @(negedge clk);
        send_frame(8'h11, 1'b0, 1'b1);
        check(rx_ready === 1'b1, "R7 ready held", rx_ready, 1);
        check(err_overrun === 1'b0, "R8 no overrun yet", err_overrun, 0);
        send_frame(8'h22, 1'b0, 1'b1);
        check(err_overrun === 1'b1, "R8 overrun flag", err_overrun, 1);
        check(hold_data === 8'h22, "R8 overwritten", hold_data, 8'h22);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        check(rx_ready === 1'b0, "R7 read clears ready", rx_ready, 0);
        check(err_overrun === 1'b1, "R9 overrun survives read", err_overrun, 1);
        clear_errs();
        check_flags("R9 overrun cleared", 4'b0000);
        auto_rd = 1'b1;

        // R10 disabled receiver
        rx_enable = 1'b0;
        send_frame(8'h5A, 1'b0, 1'b1);
        send_frame(8'h00, 1'b0, 1'b0);
        check(rx_ready === 1'b0, "R10 disabled no char", rx_ready, 0);
        check_flags("R10 disabled no flags", 4'b0000);
        check(hold_data === 8'h22, "R10 hold unchanged", hold_data, 8'h22);
        rx_enable = 1'b1;
        idle_bits(1);
        send_ok(8'h7E, 1'b0, 1'b1);
        idle_bits(2);
        check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);

        finish_run();
    end

endmodule